// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that fetches, decodes, executes, accesses memory and writes back one instruction per clock period. It handles eight instructions: word load, word store, add, subtract, bitwise AND, bitwise OR, signed set-on-less-than and branch-if-equal. Inside the core are the program counter, a 32-entry register file, the immediate sign extender, the ALU and the branch-target adder. Control is split between an opcode decoder and a second decoder. The opcode decoder produces the datapath steering bits and a 2-bit ALU class. The second decoder combines that class with the function field of register-format words to select a 3-bit ALU operation.

The core drives a word-aligned address to an external instruction ROM and expects the instruction word back in the same cycle. It drives an address, write data and a write strobe to an external data RAM and expects read data back combinationally. The RAM is written on the rising clock edge. Both memories index words by address bits [31:2]. A synchronous active-high reset loads the program counter with a parameterised start address, which is 0 by default.

Top module: `cpu_core`

## Requirements
- R1: While reset is high at a rising edge, the program counter takes the value RESET_PC (0 by default), and `imem_addr` shows that value.
- R2: Every instruction other than a taken branch advances the program counter by 4.
- R3: A word load (opcode 100011, base field [25:21], target field [20:16], offset field [15:0]) reads the data word at base plus sign-extended offset and writes it into the target register. The word 0x8C0B0004 loads the word at address 0x4 into register 11.
- R4: A word store (opcode 101011) drives `dmem_we`=1, `dmem_addr`=base plus sign-extended offset and `dmem_wdata`=the register in field [20:16], all in the same cycle.
- R5: Register-format words (opcode 000000, sources at [25:21] and [20:16], destination at [15:11], funct at [5:0]) with funct 100000 write the sum of the two sources and with funct 100010 write first minus second.
- R6: Funct 100100 writes the bitwise AND of the two sources, and funct 100101 writes the bitwise OR.
- R7: Funct 101010 writes 1 when the first source is less than the second as a signed 32-bit value, and writes 0 otherwise.
- R8: Branch-if-equal (opcode 000100) sets the next PC to PC+4+(sign-extended offset×4) when the two registers are equal, and to PC+4 when they differ. Backward offsets are supported.
- R9: Register 0 always reads as zero. A load or an ALU result aimed at register 0 is discarded.
- R10: An opcode outside the four listed, a register-format funct outside the five listed, or a register-format word with a non-zero shift field [10:6] writes no register and no memory word, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the program counter) |
| imem_rdata | input | 32 | Instruction word returned by the ROM for `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Data memory write strobe, taken on the rising edge |
| dmem_rdata | input | 32 | Data word returned by the RAM for `dmem_addr` |

## Verification
The bench builds the core with its defaults: a start address of 0 and 32 registers. This lets every program start at ROM word 0 and use all five register-field bits, so destinations such as register 11 can be reached. The bench places 64-word ROM and RAM models around the core. Each program preloads operands with loads, computes, and stores the results to RAM, where the bench compares them with values worked out by hand. A signed operand pair separates signed from unsigned comparison. A counted loop that branches backward exercises negative branch offsets. Port checks taken during the cycle of a store, a taken branch or an unsupported word confirm the strobe and the next fetch address.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int OP_W     = 6;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [OP_W-1:0] {
        OPC_REG   = 6'b000000,
        OPC_LOAD  = 6'b100011,
        OPC_STORE = 6'b101011,
        OPC_BEQ   = 6'b000100
    } opcode_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 6'b100000,
        FN_SUB = 6'b100010,
        FN_AND = 6'b100100,
        FN_OR  = 6'b100101,
        FN_SLT = 6'b101010
    } funct_e;

    typedef enum logic [1:0] {
        ACLS_ADD   = 2'b00,
        ACLS_SUB   = 2'b01,
        ACLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        AOP_AND = 3'b000,
        AOP_OR  = 3'b001,
        AOP_ADD = 3'b010,
        AOP_SUB = 3'b110,
        AOP_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        ridx_t             rs;
        ridx_t             rt;
        ridx_t             rd;
        logic [4:0]        shamt;
        logic [FN_W-1:0]   funct;
    } ifmt_t;

    typedef struct packed {
        logic       reg_write;
        logic       dst_is_rd;
        logic       b_is_imm;
        alu_class_e alu_class;
        logic       branch;
        logic       mem_write;
        logic       wb_from_mem;
    } ctrl_t;

    function automatic word_t sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/cpu_main_dec.sv
module cpu_main_dec
    import cpu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
                 alu_class: ACLS_ADD, branch: 1'b0, mem_write: 1'b0,
                 wb_from_mem: 1'b0};
        case (opcode)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_class = ACLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_class = ACLS_SUB;
                ctrl.branch    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu_alu_dec.sv
module cpu_alu_dec
    import cpu_pkg::*;
(
    input  alu_class_e      alu_class,
    input  logic [FN_W-1:0] funct,
    input  logic [4:0]      shamt,
    output alu_op_e         alu_op,
    output logic            op_ok
);
    always_comb begin
        alu_op = AOP_ADD;
        op_ok  = 1'b1;
        case (alu_class)
            ACLS_ADD: alu_op = AOP_ADD;
            ACLS_SUB: alu_op = AOP_SUB;
            default: begin
                case (funct)
                    FN_ADD:  alu_op = AOP_ADD;
                    FN_SUB:  alu_op = AOP_SUB;
                    FN_AND:  alu_op = AOP_AND;
                    FN_OR:   alu_op = AOP_OR;
                    FN_SLT:  alu_op = AOP_SLT;
                    default: op_ok  = 1'b0;
                endcase
                if (shamt != '0) op_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);
    word_t diff;

    always_comb begin
        diff = a - b;
        case (op)
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_ADD: y = a + b;
            AOP_SUB: y = diff;
            AOP_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic  clk,
    input  ridx_t ra1,
    input  ridx_t ra2,
    output word_t rd1,
    output word_t rd2,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd
);
    localparam int AW = $clog2(NREGS);

    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && (wa != '0) && (int'(wa) < NREGS))
            regs[wa[AW-1:0]] <= wd;
    end

    assign rd1 = (ra1 == '0 || int'(ra1) >= NREGS) ? '0 : regs[ra1[AW-1:0]];
    assign rd2 = (ra2 == '0 || int'(ra2) >= NREGS) ? '0 : regs[ra2[AW-1:0]];
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0,
    parameter int          NREGS    = 32
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    word_t      pc_q;
    ifmt_t      ir;
    ctrl_t      ctrl;
    alu_op_e    alu_op;
    logic       op_ok;
    logic       rf_we;
    ridx_t      wr_idx;
    word_t      rs_val;
    word_t      rt_val;
    word_t      simm;
    word_t      src_b;
    word_t      alu_y;
    logic       alu_zero;
    word_t      wb_data;
    word_t      pc_plus4;
    word_t      pc_target;
    word_t      pc_next;

    assign ir = ifmt_t'(imem_rdata);

    cpu_main_dec u_main_dec (
        .opcode (ir.opcode),
        .ctrl   (ctrl)
    );

    cpu_alu_dec u_alu_dec (
        .alu_class (ctrl.alu_class),
        .funct     (ir.funct),
        .shamt     (ir.shamt),
        .alu_op    (alu_op),
        .op_ok     (op_ok)
    );

    assign simm   = sext_imm({ir.rd, ir.shamt, ir.funct});
    assign wr_idx = ctrl.dst_is_rd ? ir.rd : ir.rt;
    assign rf_we  = ctrl.reg_write & op_ok;

    cpu_regfile #(.NREGS(NREGS)) u_rf (
        .clk (clk),
        .ra1 (ir.rs),
        .ra2 (ir.rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (wr_idx),
        .wd  (wb_data)
    );

    assign src_b = ctrl.b_is_imm ? simm : rt_val;

    cpu_alu u_alu (
        .a    (rs_val),
        .b    (src_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_data   = ctrl.wb_from_mem ? dmem_rdata : alu_y;
    assign pc_plus4  = pc_q + 32'd4;
    assign pc_target = pc_plus4 + {simm[XLEN-3:0], 2'b00};
    assign pc_next   = (ctrl.branch && alu_zero) ? pc_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_next;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_write;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_we,
    input logic        rf_we,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val
);
    logic [5:0]  c_op;
    logic [5:0]  c_fn;
    logic        c_known;
    logic        c_taken;
    logic [31:0] c_off;

    assign c_op = imem_rdata[31:26];
    assign c_fn = imem_rdata[5:0];
    assign c_known = (c_op == 6'b100011) || (c_op == 6'b101011) || (c_op == 6'b000100) ||
                     ((c_op == 6'b000000) && (imem_rdata[10:6] == 5'd0) &&
                      ((c_fn == 6'b100000) || (c_fn == 6'b100010) || (c_fn == 6'b100100) ||
                       (c_fn == 6'b100101) || (c_fn == 6'b101010)));
    assign c_taken = (c_op == 6'b000100) && (rs_val == rt_val);
    assign c_off   = {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !c_taken |=> imem_addr == $past(imem_addr) + 32'd4); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        c_taken |=> imem_addr == $past(imem_addr) + 32'd4 + $past(c_off)); // R8

    AST_STORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> c_op == 6'b101011); // R4

    AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst)
        !c_known |-> (!dmem_we && !rf_we)); // R10

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        imem_rdata[25:21] == 5'd0 |-> rs_val == 32'd0); // R9
endmodule

bind cpu_core cpu_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .rf_we      (rf_we),
    .rs_val     (rs_val),
    .rt_val     (rt_val)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [5:0] OP_R = 6'b000000, OP_LW = 6'b100011,
                           OP_SW = 6'b101011, OP_BEQ = 6'b000100;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn, input int sh = 0);
        return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            imem[i] = enc_i(OP_BEQ, 0, 0, -1);
            dmem[i] = 32'h0;
        end
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        hold_reset();
        for (int i = 0; i < 8; i++) imem[i] = enc_r(0, 0, 0, 6'b100000);
        step(2);
        check("R1 pc held at start in reset", imem_addr, 32'h0);
        release_reset();
        check("R1 pc at start after reset", imem_addr, 32'h0);
        step(3);
        check("R2 sequential pc after 3 cycles", imem_addr, 32'd12);
    endtask

    task automatic t_load();
        hold_reset();
        dmem[1]  = 32'hDEADBEEF;
        dmem[2]  = 32'h40;
        dmem[15] = 32'h12345678;
        imem[0] = 32'h8C0B0004;
        imem[1] = enc_i(OP_SW, 0, 11, 32'h20);
        imem[2] = enc_i(OP_LW, 0, 2, 8);
        imem[3] = enc_i(OP_LW, 2, 3, -4);
        imem[4] = enc_i(OP_SW, 0, 3, 32'h24);
        release_reset();
        step(12);
        check("R3 word 0x8C0B0004 loads into r11", dmem[8], 32'hDEADBEEF);
        check("R3 load with negative offset", dmem[9], 32'h12345678);
    endtask

    task automatic t_store();
        hold_reset();
        dmem[0] = 32'hA5A5A5A5;
        dmem[1] = 32'h30;
        imem[0] = enc_i(OP_LW, 0, 5, 0);
        imem[1] = enc_i(OP_LW, 0, 6, 4);
        imem[2] = enc_i(OP_SW, 6, 5, 8);
        release_reset();
        step(2);
        check("R4 store strobe", {31'b0, dmem_we}, 32'h1);
        check("R4 store address", dmem_addr, 32'h38);
        check("R4 store data", dmem_wdata, 32'hA5A5A5A5);
        step(8);
        check("R4 stored word in memory", dmem[14], 32'hA5A5A5A5);
    endtask

    task automatic t_alu();
        hold_reset();
        dmem[0] = 32'd7;
        dmem[1] = 32'hFFFFFFFD;
        imem[0] = enc_i(OP_LW, 0, 1, 0);
        imem[1] = enc_i(OP_LW, 0, 2, 4);
        imem[2] = enc_r(1, 2, 3, 6'b100000);
        imem[3] = enc_r(1, 2, 4, 6'b100010);
        imem[4] = enc_r(1, 2, 5, 6'b100100);
        imem[5] = enc_r(1, 2, 6, 6'b100101);
        imem[6] = enc_r(1, 2, 7, 6'b101010);
        imem[7] = enc_r(2, 1, 8, 6'b101010);
        for (int i = 0; i < 6; i++) imem[8+i] = enc_i(OP_SW, 0, 3+i, 64 + 4*i);
        release_reset();
        step(20);
        check("R5 add 7+(-3)", dmem[16], 32'd4);
        check("R5 sub 7-(-3)", dmem[17], 32'd10);
        check("R6 and", dmem[18], 32'h5);
        check("R6 or", dmem[19], 32'hFFFFFFFF);
        check("R7 slt 7<-3 signed", dmem[20], 32'd0);
        check("R7 slt -3<7 signed", dmem[21], 32'd1);
    endtask

    task automatic t_r0();
        hold_reset();
        dmem[0]  = 32'd9;
        dmem[10] = 32'hFFFF0000;
        dmem[11] = 32'hFFFF0000;
        imem[0] = enc_i(OP_LW, 0, 1, 0);
        imem[1] = enc_r(1, 1, 0, 6'b100000);
        imem[2] = enc_i(OP_SW, 0, 0, 40);
        imem[3] = enc_i(OP_LW, 0, 0, 0);
        imem[4] = enc_i(OP_SW, 0, 0, 44);
        release_reset();
        step(10);
        check("R9 r0 after add write", dmem[10], 32'h0);
        check("R9 r0 after load write", dmem[11], 32'h0);
    endtask

    task automatic t_branch();
        hold_reset();
        dmem[0] = 32'd5; dmem[1] = 32'd5; dmem[2] = 32'd9;
        dmem[3] = 32'd1; dmem[4] = 32'd3;
        imem[0]  = enc_i(OP_LW, 0, 1, 0);
        imem[1]  = enc_i(OP_LW, 0, 2, 4);
        imem[2]  = enc_i(OP_LW, 0, 3, 8);
        imem[3]  = enc_i(OP_LW, 0, 5, 12);
        imem[4]  = enc_i(OP_LW, 0, 6, 16);
        imem[5]  = enc_i(OP_BEQ, 1, 2, 2);
        imem[6]  = enc_i(OP_SW, 0, 5, 32'h80);
        imem[7]  = enc_i(OP_SW, 0, 5, 32'h84);
        imem[8]  = enc_i(OP_BEQ, 1, 3, 1);
        imem[9]  = enc_i(OP_SW, 0, 6, 32'h88);
        imem[10] = enc_r(4, 4, 4, 6'b100010);
        imem[11] = enc_r(4, 5, 4, 6'b100000);
        imem[12] = enc_i(OP_BEQ, 4, 6, 1);
        imem[13] = enc_i(OP_BEQ, 0, 0, -3);
        imem[14] = enc_i(OP_SW, 0, 4, 32'h8C);
        release_reset();
        step(5);
        check("R2 pc before branch", imem_addr, 32'd20);
        step(1);
        check("R8 taken forward branch target", imem_addr, 32'd32);
        step(1);
        check("R8 not-taken branch falls through", imem_addr, 32'd36);
        step(30);
        check("R8 skipped store 1", dmem[32], 32'h0);
        check("R8 skipped store 2", dmem[33], 32'h0);
        check("R8 fall-through store", dmem[34], 32'd3);
        check("R8 backward loop count", dmem[35], 32'd3);
    endtask

    task automatic t_unsupported();
        hold_reset();
        dmem[0]  = 32'h55;
        dmem[17] = 32'hCAFE;
        imem[0] = enc_i(OP_LW, 0, 7, 0);
        imem[1] = enc_i(6'b001000, 0, 7, 32'h11);
        imem[2] = enc_r(0, 0, 7, 6'b000000);
        imem[3] = enc_r(0, 0, 7, 6'b100000, 3);
        imem[4] = enc_i(6'b100001, 0, 7, 0);
        imem[5] = enc_i(6'b101001, 0, 0, 32'h44);
        imem[6] = enc_i(OP_SW, 0, 7, 32'h40);
        release_reset();
        step(1);
        check("R10 unknown opcode no store strobe", {31'b0, dmem_we}, 32'h0);
        step(1);
        check("R10 pc advances past unknown opcode", imem_addr, 32'd8);
        step(3);
        check("R10 store-like unknown opcode no strobe", {31'b0, dmem_we}, 32'h0);
        step(1);
        check("R10 pc after unsupported run", imem_addr, 32'd24);
        step(6);
        check("R10 register unchanged", dmem[16], 32'h55);
        check("R10 memory unchanged", dmem[17], 32'hCAFE);
    endtask

    initial begin
        t_reset();
        t_load();
        t_store();
        t_alu();
        t_r0();
        t_branch();
        t_unsupported();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule